// File: doc/BRIEF.md
# System Clock Prescaler

This block slows a source clock by a software-chosen ratio between 2 and 129 so that logic which needs little throughput draws less power. Software controls it through one 8-bit control register that holds a division-enable flag and a 7-bit ratio code. Writes arrive through a strobe and a data byte. Reads return what the register actually holds, which may differ from what was last written.

The divided rate is produced in two forms. The first is a clock-enable strobe that is high for one source cycle per divided period. The second is a gated clock, built from the strobe through a latch-based gate, so that no runt pulse appears when the ratio changes or division is switched on or off. While division is off, the strobe is high on every cycle and the gated clock follows the source clock.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset the read port returns 0x00 and the strobe is high on every cycle.
- R2: With division enabled and stored code d, the strobe is high on exactly one cycle out of every (129 − d) source cycles.
- R3: Bit 7 of the register is the division enable and bits 6:0 are the code d. Ratio 2 is d = 127 and ratio 129 is d = 0.
- R4: A write with bit 7 = 1 while division is off stores bit 7 and the code from the same write. The stored value is visible on the read port on the following cycle.
- R5: A write with bit 7 = 1 while division is already on changes neither the stored code nor the running period.
- R6: A write with bit 7 = 0 clears the enable and leaves the stored code unchanged, whatever code bits it carries.
- R7: While the stored enable is 0, the strobe is high on every cycle. This begins on the cycle after the disabling write.
- R8: When division is switched on, the divider restarts at count 0. The first strobe then comes (128 − d) cycles after the first enabled cycle.
- R9: The gated clock output is high during a high phase of the source clock only when the strobe was high in the low phase just before it. Otherwise it stays low for that whole phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Stored register contents |
| tick | output | 1 | One-cycle clock-enable strobe at the divided rate |
| clk_out | output | 1 | Glitch-free gated clock |

## Verification
Two events can fall in the same cycle: a register write that switches division off, and the wrap of the divider that raises the strobe. The bench provokes this by waiting until the strobe is high and then placing the disabling write in that very cycle. It then checks that the strobe stays high on every following cycle and that the stored code has not moved. A second collision comes from a write that tries to re-enable with a new code in the middle of a period. It is judged by checking that the next strobe still arrives at the old spacing.

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_data,
  output logic [CODE_W:0]   rd_data,
  output logic              tick,
  output logic              clk_out
);
  localparam int CNT_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(2 ** CODE_W);

  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic              gate_en;

  assign limit   = TOP - CNT_W'(code_q);
  assign tick    = !en_q || (cnt_q == limit);
  assign rd_data = {en_q, code_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (wr_en) begin
      if (!wr_data[CODE_W]) begin
        en_q <= 1'b0;
      end else if (!en_q) begin
        en_q   <= 1'b1;
        code_q <= wr_data[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en_q)      cnt_q <= '0;
    else if (cnt_q == limit) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  always_latch begin
    if (!clk) gate_en = tick;
  end

  assign clk_out = clk & gate_en;
endmodule

module sysclk_prescaler_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CODE_W:0]   wr_data,
  input logic [CODE_W:0]   rd_data,
  input logic              tick
);
  localparam int CNT_W = CODE_W + 1;
  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] lim;
  assign lim = CNT_W'(2 ** CODE_W) - CNT_W'(rd_data[CODE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap <= '0;
    else if (!rd_data[CODE_W] || tick) gap <= '0;
    else                             gap <= gap + 1'b1;
  end

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[CODE_W] && !rd_data[CODE_W] |=> rd_data == $past(wr_data));
  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[CODE_W] && rd_data[CODE_W] |=> $stable(rd_data));
  a_r6_keep_code: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[CODE_W] |=> !rd_data[CODE_W] && rd_data[CODE_W-1:0] == $past(rd_data[CODE_W-1:0]));
  a_r7_always_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[CODE_W] |-> tick);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[CODE_W]) |-> !tick);
  a_r2_period: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CODE_W] && tick |-> gap == lim);
  a_r2_no_late: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CODE_W] |-> gap <= lim);
endmodule

bind sysclk_prescaler sysclk_prescaler_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tick(tick)
);

// File: tb/sysclk_prescaler_bench.sv
`timescale 1ns/1ps
module sysclk_prescaler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tick, clk_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysclk_prescaler u_sysclk_prescaler (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // cycles from now until tick is high (now counts as 0); also checks gated clock
  task automatic wait_tick(output int k, inout int gate_bad);
    k = 0;
    while (!tick && k < 300) begin
      @(posedge clk); #1;
      if (clk_out !== 1'b0) gate_bad++;
      @(negedge clk); k++;
    end
    @(posedge clk); #1;
    if (clk_out !== 1'b1) gate_bad++;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int k, gb, all_ones;
    #5; rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R1 reset value", rd_data, 0);
    all_ones = 1;
    for (int i = 0; i < 5; i++) begin
      if (!tick) all_ones = 0;
      @(negedge clk);
    end
    chk(all_ones == 1, "R1 strobe high after reset", all_ones, 1);

    for (int d = 0; d < 128; d++) begin
      wr({1'b1, 7'(d)});
      chk(rd_data == {1'b1, 7'(d)}, "R4 load on enable", rd_data, {1'b1, 7'(d)});
      gb = 0;
      wait_tick(k, gb);
      chk(k == 128 - d, "R8 first strobe after restart", k, 128 - d);
      wait_tick(k, gb);
      chk(k + 1 == 129 - d, "R2 R3 period", k + 1, 129 - d);
      chk(gb == 0, "R9 gated clock", gb, 0);
      wr(8'h00);
    end

    // R5: re-enable attempt with a new code mid-period is ignored
    wr({1'b1, 7'd120});
    gb = 0;
    wait_tick(k, gb);
    @(negedge clk); @(negedge clk);
    wr({1'b1, 7'd0});
    chk(rd_data == {1'b1, 7'd120}, "R5 locked code", rd_data, {1'b1, 7'd120});
    wait_tick(k, gb);
    chk(k + 5 == 9, "R5 period unchanged", k + 5, 9);

    // R6/R7: disable in the same cycle as a wrap, with nonzero code bits
    wait_tick(k, gb);
    k = 0;
    while (!tick) begin @(negedge clk); k++; end
    wr_en = 1'b1; wr_data = 8'h3F;
    @(negedge clk); wr_en = 1'b0;
    chk(rd_data == 8'h78, "R6 code kept on disable", rd_data, 8'h78);
    all_ones = 1;
    for (int i = 0; i < 20; i++) begin
      if (!tick) all_ones = 0;
      @(negedge clk);
    end
    chk(all_ones == 1, "R7 strobe high when disabled", all_ones, 1);
    wr(8'h85);
    chk(rd_data == 8'h85, "R4 reload after disable", rd_data, 8'h85);
    wait_tick(k, gb);
    chk(k == 123, "R8 restart after reload", k, 123);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule